// File: doc/BRIEF.md
# Packed Continuous Bus-Signal Sampler

This block watches eight slow digital lines of an external parallel bus: the active-low read enable, the active-low upper-byte write strobe, the active-low lower-byte write strobe, and the five lowest word-address lines (A5 down to A1). At a fixed rate, set by a programmable divider of the system clock, it takes one snapshot of all eight lines. Each snapshot is packed into one byte and sent to a host over a valid/ready byte stream. Snapshots are taken whether or not any line is changing, so the host gets an evenly spaced time record. It can rebuild the strobe timing and the low address bits from that record. No data-bus lines are captured.

The lines are synchronised with two flip-flops before packing. A small FIFO absorbs short stalls on the output side. If the FIFO is full when a snapshot is due, the snapshot is dropped and a sticky overrun flag is raised. A capture-enable input starts and stops sampling. Bytes already queued keep draining after capture stops.

Top module: `sig_sampler`

## Requirements
- R1: Each output byte has this layout: bit 0 is the read-enable line, bit 1 is the lower write strobe, bit 2 is the upper write strobe, and bits 7..3 are A5..A1 with A1 in bit 3. All eight bits of one byte come from the same clock edge.
- R2: While capture is enabled with a divide value N ≥ 1, exactly one sample is taken every N clocks. This holds even when every input is constant.
- R3: A divide value of 1 samples on every clock while enabled. A divide value of 0 behaves like 1. The first sample is taken in the N-th enabled cycle.
- R4: Each input passes through two synchroniser flops. A sample taken at a clock edge reflects the input levels that were present two edges earlier.
- R5: Samples leave in the order they were taken, through a 16-entry FIFO. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold.
- R6: A sample that falls due while the FIFO holds 16 bytes is discarded, and `overrun` is set. A pop in the same cycle does not make room for that sample. `overrun` then stays high.
- R7: `overrun` clears on the clock edge at which `cap_en` is first seen high after being low. A discard in that same cycle still sets it.
- R8: With `cap_en` low, no new samples are taken. Bytes already in the FIFO still drain through the handshake.
- R9: After reset, `out_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| div_val | input | DIV_W (16) | Sample period in clocks (0 treated as 1) |
| rd_en_n_in | input | 1 | Observed read-enable line, active low |
| lo_wr_n_in | input | 1 | Observed lower-byte write strobe, active low |
| up_wr_n_in | input | 1 | Observed upper-byte write strobe, active low |
| addr_in | input | 5 | Observed address lines A5..A1 (bit 0 = A1) |
| out_data | output | 8 | Packed sample byte |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Host accepts the byte |
| overrun | output | 1 | Sticky flag: a sample was dropped |

## Verification
The bench first drives a walking one and then a walking zero across all eight inputs while sampling every clock. A swapped or shifted bit position shows up as a wrong byte, and a wrong synchroniser depth shows up as a one-cycle skew. Constant inputs under a divide value of 4, and then 0, separate a correct sample period from a design that only captures on change or miscounts the period. A stalled sink fills the FIFO and overflows it, which checks the discard rule, the full boundary and data hold. Stopping and restarting capture while the FIFO drains shows whether sampling really halts, whether queued bytes survive, and whether the overrun flag clears at the right edge.

// File: rtl/samp_pkg.sv
// Shared types for the packed bus sampler.
// Assumes: address field carries A5..A1 with A1 in its LSB.
package samp_pkg;

    localparam int ADDR_BITS = 5;

    // One packed sample; read enable sits in bit 0.
    typedef struct packed {
        logic [ADDR_BITS-1:0] addr;
        logic                 up_wr_n;
        logic                 lo_wr_n;
        logic                 rd_en_n;
    } samp_byte_t;

    localparam int SAMP_W = $bits(samp_byte_t);

endpackage

// File: rtl/samp_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: each bit changes slowly relative to clk; bits are sampled
// together so a bundle word is taken from a single edge.
module samp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop stage captures the raw inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d_in;
                end
            end else begin : g_next
                // Later stages shift the word along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= '0;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/samp_rate.sv
// Sample-rate divider: asserts tick once every div_val clocks while enabled.
// Assumes: div_val of 0 means 1; the counter restarts from zero whenever
// enable is low, so the first tick comes in the div_val-th enabled cycle.
module samp_rate #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim_m1;

    // Period minus one, with zero folded onto one.
    always_comb begin
        if (div_val == '0) lim_m1 = '0;
        else               lim_m1 = div_val - DIV_W'(1);
    end

    assign tick = en && (cnt >= lim_m1);

    // Count enabled cycles and wrap at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + DIV_W'(1);
    end

endmodule

// File: rtl/samp_fifo.sv
// Synchronous byte FIFO with a first-word-fall-through output.
// Assumes: DEPTH is a power of two; a write while full is refused even
// if a read happens in the same cycle.
module samp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    input  logic             rd_ready
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_wr, do_rd;

    assign full     = (count == CW'(DEPTH));
    assign rd_valid = (count != '0);
    assign rd_data  = mem[rd_ptr];
    assign do_wr    = wr_en && !full;
    assign do_rd    = rd_valid && rd_ready;

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + AW'(1);
            if (do_rd) rd_ptr <= rd_ptr + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sig_sampler.sv
// Top level: synchronise eight bus lines, pack them into one byte at the
// divided sample rate, queue the bytes and flag any that are dropped.
// Assumes: cap_en and div_val are synchronous to clk; the observed lines
// are asynchronous.
module sig_sampler
    import samp_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic [DIV_W-1:0]     div_val,
    input  logic                 rd_en_n_in,
    input  logic                 lo_wr_n_in,
    input  logic                 up_wr_n_in,
    input  logic [ADDR_BITS-1:0] addr_in,
    output logic [SAMP_W-1:0]    out_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 overrun
);

    samp_byte_t raw_word;
    logic [SAMP_W-1:0] sync_word;
    logic sample_tick;
    logic fifo_full;
    logic en_q;
    logic cap_start;

    // Pack the raw lines in the output bit order before synchronising.
    always_comb begin
        raw_word.addr    = addr_in;
        raw_word.up_wr_n = up_wr_n_in;
        raw_word.lo_wr_n = lo_wr_n_in;
        raw_word.rd_en_n = rd_en_n_in;
    end

    samp_sync #(.WIDTH(SAMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_word),
        .d_out (sync_word)
    );

    samp_rate #(.DIV_W(DIV_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cap_en),
        .div_val (div_val),
        .tick    (sample_tick)
    );

    samp_fifo #(.WIDTH(SAMP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sample_tick),
        .wr_data  (sync_word),
        .full     (fifo_full),
        .rd_data  (out_data),
        .rd_valid (out_valid),
        .rd_ready (out_ready)
    );

    assign cap_start = cap_en && !en_q;

    // Remember the previous enable level to detect a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= cap_en;
    end

    // Sticky overrun: set on a dropped sample, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                        overrun <= 1'b0;
        else if (sample_tick && fifo_full) overrun <= 1'b1;
        else if (cap_start)                overrun <= 1'b0;
    end

endmodule

// File: rtl/sig_sampler_chk.sv
// Property checker for sig_sampler, attached through bind.
// Assumes: sampled on the rising clock; all properties idle during reset.
module sig_sampler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cap_en,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       overrun,
    input logic       sample_tick,
    input logic       fifo_full,
    input logic [15:0] div_val
);

    // R5: stalled output holds its byte.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6: overrun is sticky until restart.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !$rose(cap_en) |=> overrun);

    // R6: a due sample into a full queue raises overrun.
    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick && fifo_full |=> overrun);

    // R8: no sampling while capture is off.
    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |-> !sample_tick);

    // R3: divide of 0 or 1 samples every enabled clock.
    p_every_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en && div_val <= 16'd1 |-> sample_tick);

    // R9: reset leaves the stream empty and the flag clear.
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !overrun);

endmodule

bind sig_sampler sig_sampler_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .overrun     (overrun),
    .sample_tick (sample_tick),
    .fifo_full   (fifo_full),
    .div_val     (div_val)
);

// File: tb/sim_sig_sampler.sv
`timescale 1ns/1ps
module sim_sig_sampler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic [15:0] div_val = 16'd1;
    logic        rd_en_n_in = 1'b1, lo_wr_n_in = 1'b1, up_wr_n_in = 1'b1;
    logic [4:0]  addr_in = 5'd0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        overrun;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R9";
    bit    chk_on = 1'b0;
    bit    done = 1'b0;

    // Reference model state.
    logic [7:0] m_s1, m_s2;
    int         m_cnt;
    logic [7:0] m_q[$];
    bit         m_ovf, m_enq;

    always #4 clk = ~clk;

    sig_sampler u0 (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .div_val(div_val),
        .rd_en_n_in(rd_en_n_in), .lo_wr_n_in(lo_wr_n_in), .up_wr_n_in(up_wr_n_in),
        .addr_in(addr_in), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .overrun(overrun)
    );

    function automatic logic [7:0] pack_in();
        return {addr_in, up_wr_n_in, lo_wr_n_in, rd_en_n_in};
    endfunction

    // Behavioural model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_cnt = 0; m_q.delete(); m_ovf = 0; m_enq = 0;
        end else begin
            int lim;
            bit tk, pop, full;
            lim  = (div_val == 0) ? 1 : int'(div_val);
            tk   = cap_en && (m_cnt >= lim - 1);
            pop  = out_ready && (m_q.size() > 0);
            full = (m_q.size() == 16);
            if (tk && full)            m_ovf = 1;
            else if (cap_en && !m_enq) m_ovf = 0;
            if (pop) void'(m_q.pop_front());
            if (tk && !full) m_q.push_back(m_s2);
            if (!cap_en || tk) m_cnt = 0; else m_cnt++;
            m_enq = cap_en;
            m_s2 = m_s1;
            m_s1 = pack_in();
        end
        chk_on = 1'b1;
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            bit ev;
            ev = (m_q.size() > 0);
            n_chk++;
            if (out_valid !== ev) begin
                n_fail++;
                $display("FAIL %s valid: actual %b expected %b", tag, out_valid, ev);
            end
            if (ev) begin
                n_chk++;
                if (out_data !== m_q[0]) begin
                    n_fail++;
                    $display("FAIL %s data: actual %h expected %h", tag, out_data, m_q[0]);
                end
            end
            n_chk++;
            if (overrun !== m_ovf) begin
                n_fail++;
                $display("FAIL %s overrun: actual %b expected %b", tag, overrun, m_ovf);
            end
        end
    end

    task automatic set_in(input logic [7:0] v);
        {addr_in, up_wr_n_in, lo_wr_n_in, rd_en_n_in} = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        tag = "R9";
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 R4 R3: walking one then walking zero, divide 1.
        tag = "R1/R4 walk";
        div_val = 16'd1;
        cap_en = 1'b1;
        for (int i = 0; i < 8; i++) begin set_in(8'h01 << i); wait_cyc(1); end
        for (int i = 0; i < 8; i++) begin set_in(~(8'h01 << i)); wait_cyc(1); end
        set_in(8'hA5);
        wait_cyc(3);
        cap_en = 1'b0;
        wait_cyc(20);
        // R2: constant inputs, divide 4.
        tag = "R2 div4";
        set_in(8'h3C);
        div_val = 16'd4;
        cap_en = 1'b1;
        wait_cyc(30);
        cap_en = 1'b0;
        wait_cyc(4);
        // R3: divide 0 acts as 1.
        tag = "R3 div0";
        div_val = 16'd0;
        set_in(8'h5A);
        cap_en = 1'b1;
        wait_cyc(6);
        cap_en = 1'b0;
        wait_cyc(10);
        // R5 R6: stall sink, fill and overflow.
        tag = "R5/R6 full";
        out_ready = 1'b0;
        div_val = 16'd1;
        cap_en = 1'b1;
        for (int i = 0; i < 22; i++) begin set_in(8'(i * 7 + 3)); wait_cyc(1); end
        // R6: pop while full still drops the due sample.
        tag = "R6 popfull";
        out_ready = 1'b1;
        wait_cyc(1);
        out_ready = 1'b0;
        wait_cyc(3);
        // R8: stop capture, drain, flag stays set.
        tag = "R8 drain";
        cap_en = 1'b0;
        set_in(8'hFF);
        wait_cyc(2);
        out_ready = 1'b1;
        wait_cyc(24);
        // R7: restart clears overrun.
        tag = "R7 restart";
        div_val = 16'd3;
        cap_en = 1'b1;
        wait_cyc(12);
        cap_en = 1'b0;
        wait_cyc(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule